// File: doc/BRIEF.md
# Embedded Operation Status Reporter

While a flash array runs an internally timed program or erase, a host cannot read real array contents. This block sits on the read data path and places status information in two bit positions of every word the host reads. The poll bit reports the complement of the poll bit of the word just written during a program, and reports 0 during an erase. The toggle bit flips on each successive read for as long as the operation lasts. When busy falls, both bits go back to array data. A host can therefore detect completion by re-reading until the word becomes stable or correct.

The block also drives the enable of an open-drain ready/busy pin. The enable pulls the pin low while an operation runs and leaves it released otherwise. The array, its timers and the command decoder that raises busy are outside the block.

Top module: `flash_op_status`

## Requirements
- R1: While busy_i is 0, rd_data_o equals array_rd_data_i in all 16 bits.
- R2: While busy_i is 1 and op_is_erase_i is 0 (program), rd_data_o[7] is the inverse of last_wr_data_i[7].
- R3: While busy_i is 1 and op_is_erase_i is 1 (erase), rd_data_o[7] is 0.
- R4: While busy_i is 1, rd_data_o[6] shows the toggle state. The toggle state inverts at every rising clock edge where rd_strobe_i is 1. The first read of an operation shows 0, so successive reads give 0, 1, 0, ...
- R5: While busy_i is 1, clock edges without rd_strobe_i leave rd_data_o[6] unchanged.
- R6: When busy_i is 0, the toggle state is cleared at the next clock edge, so the next operation starts again at 0.
- R7: rdy_pull_low_o is 1 exactly while busy_i is 1 and reset is not asserted.
- R8: Asserting rst_n low immediately forces rdy_pull_low_o to 0, even while busy_i is 1, and clears the toggle state.
- R9: While busy_i is 1, every bit except bits 7 and 6 equals array_rd_data_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Internal program or erase in progress |
| op_is_erase_i | input | 1 | 1 = erase, 0 = program |
| last_wr_data_i | input | 16 | Last data word loaded for the operation |
| rd_strobe_i | input | 1 | One cycle per completed host read |
| array_rd_data_i | input | 16 | Data read from the array |
| rd_data_o | output | 16 | Read word returned to the host |
| rdy_pull_low_o | output | 1 | Enable for the open-drain ready/busy pin pull-down |

## Verification
The hardest situations to reach are two that depend on history. The first is an operation that begins after an earlier one ended with the toggle state at 1. The second is a reset that arrives in the middle of a busy period. To reach them, the stimulus ends a program after an odd number of reads and then starts an erase, which must read 0 first. It also pulls reset low while busy with reads pending and checks the pin release and a fresh toggle sequence once reset is released. Idle clock edges between strobes show that time alone never advances the toggle bit.

// File: rtl/flash_op_status.sv
module flash_op_status #(
  parameter int W        = 16,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy_i,
  input  logic         op_is_erase_i,
  input  logic [W-1:0] last_wr_data_i,
  input  logic         rd_strobe_i,
  input  logic [W-1:0] array_rd_data_i,
  output logic [W-1:0] rd_data_o,
  output logic         rdy_pull_low_o
);

  logic tgl_q;
  logic poll_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tgl_q <= 1'b0;
    else if (!busy_i)     tgl_q <= 1'b0;
    else if (rd_strobe_i) tgl_q <= ~tgl_q;
  end

  assign poll_val = op_is_erase_i ? 1'b0 : ~last_wr_data_i[POLL_BIT];

  always_comb begin
    rd_data_o = array_rd_data_i;
    if (busy_i) begin
      rd_data_o[POLL_BIT] = poll_val;
      rd_data_o[TGL_BIT]  = tgl_q;
    end
  end

  assign rdy_pull_low_o = busy_i & rst_n;

endmodule

// File: rtl/flash_op_status_chk.sv
module flash_op_status_chk #(
  parameter int W        = 16,
  parameter int POLL_BIT = 7,
  parameter int TGL_BIT  = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy_i,
  input logic         op_is_erase_i,
  input logic [W-1:0] last_wr_data_i,
  input logic         rd_strobe_i,
  input logic [W-1:0] array_rd_data_i,
  input logic [W-1:0] rd_data_o,
  input logic         rdy_pull_low_o
);

  a_r2_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !op_is_erase_i) |-> (rd_data_o[POLL_BIT] != last_wr_data_i[POLL_BIT]));

  a_r3_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && op_is_erase_i) |-> !rd_data_o[POLL_BIT]);

  a_r4_toggle_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i) && $past(rd_strobe_i)) |-> (rd_data_o[TGL_BIT] != $past(rd_data_o[TGL_BIT])));

  a_r5_hold_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i) && !$past(rd_strobe_i)) |-> $stable(rd_data_o[TGL_BIT]));

  a_r6_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !$past(busy_i)) |-> !rd_data_o[TGL_BIT]);

  a_r7_pin_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_pull_low_o == busy_i);

  a_r1_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (rd_data_o == array_rd_data_i));

endmodule

bind flash_op_status flash_op_status_chk #(.W(W), .POLL_BIT(POLL_BIT), .TGL_BIT(TGL_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .op_is_erase_i(op_is_erase_i),
  .last_wr_data_i(last_wr_data_i), .rd_strobe_i(rd_strobe_i),
  .array_rd_data_i(array_rd_data_i), .rd_data_o(rd_data_o),
  .rdy_pull_low_o(rdy_pull_low_o)
);

// File: tb/flash_op_status_tb.sv
module flash_op_status_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busy_i = 1'b0;
  logic        op_is_erase_i = 1'b0;
  logic [15:0] last_wr_data_i = '0;
  logic        rd_strobe_i = 1'b0;
  logic [15:0] array_rd_data_i = '0;
  logic [15:0] rd_data_o;
  logic        rdy_pull_low_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_op_status u_dut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .op_is_erase_i(op_is_erase_i),
    .last_wr_data_i(last_wr_data_i), .rd_strobe_i(rd_strobe_i),
    .array_rd_data_i(array_rd_data_i), .rd_data_o(rd_data_o),
    .rdy_pull_low_o(rdy_pull_low_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_word(output logic [15:0] w);
    @(negedge clk);
    rd_strobe_i = 1'b1;
    #1 w = rd_data_o;
    @(negedge clk);
    rd_strobe_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    check("R8 reset pin released", rdy_pull_low_o, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    array_rd_data_i = 16'hA5C3; #1;
    check("R1 idle passthrough", rd_data_o, 16'hA5C3);
    check("R7 idle pin released", rdy_pull_low_o, 0);
  endtask

  task automatic t_program;
    logic [15:0] w;
    last_wr_data_i = 16'h0080;
    array_rd_data_i = 16'h1234;
    op_is_erase_i = 1'b0;
    busy_i = 1'b1;
    #1 check("R7 busy pin pulled low", rdy_pull_low_o, 1);
    for (int i = 0; i < 3; i++) begin
      read_word(w);
      check("R2 program poll bit", w[7], 0);
      check("R4 toggle sequence", w[6], i % 2);
      check("R9 other bits pass", w & 16'hFF3F, 16'h1234 & 16'hFF3F);
    end
    last_wr_data_i = 16'h0000; #1;
    check("R2 program poll bit inverted", rd_data_o[7], 1);
    repeat (5) @(negedge clk);
    #1 check("R5 no toggle without read", rd_data_o[6], 1);
  endtask

  task automatic t_finish;
    @(negedge clk);
    busy_i = 1'b0;
    array_rd_data_i = 16'h00C0; #1;
    check("R1 data after finish", rd_data_o, 16'h00C0);
    check("R7 pin released after finish", rdy_pull_low_o, 0);
    @(negedge clk);
  endtask

  task automatic t_erase;
    logic [15:0] w;
    op_is_erase_i = 1'b1;
    last_wr_data_i = 16'h0000;
    array_rd_data_i = 16'hFFFF;
    busy_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      read_word(w);
      check("R3 erase poll zero", w[7], 0);
      check("R6 R4 erase toggle from zero", w[6], i % 2);
    end
  endtask

  task automatic t_reset_busy;
    logic [15:0] w;
    read_word(w);
    check("R4 toggle before reset", w[6], 0);
    @(negedge clk);
    rst_n = 1'b0; #1;
    check("R8 pin released in reset", rdy_pull_low_o, 0);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R7 pin low again", rdy_pull_low_o, 1);
    read_word(w);
    check("R8 toggle cleared by reset", w[6], 0);
    read_word(w);
    check("R4 toggle after reset", w[6], 1);
    @(negedge clk); busy_i = 1'b0;
  endtask

  initial begin
    t_reset;
    t_program;
    t_finish;
    t_erase;
    t_reset_busy;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule